// File: doc/BRIEF.md
# Element-Width SIMD Lane Joiner

This block merges two packed SIMD operands into one result word of fixed width. A two-bit run-time selector chooses how many equal lanes the result is cut into: one, two or four. Each lane carries an element taken from operand A in its least significant bits. Directly above that sits the matching element of operand B. Any bits of the lane left over above the B element are forced to zero. The result is therefore always the same width, whichever selector value is in use.

Operand A is read as four 4-bit slots. Only the low three bits of each slot form an element, and the slot's top bit is never used. Operand B is split into contiguous fields whose width depends on the lane count. The default build registers the result, the selector and an error flag whenever the input strobe is high, which gives one cycle of latency. Selector code 3 is reserved: it yields an all-zero result and raises the error flag.

Top module: `simd_cat`

## Requirements
- R1: Selector 0 (one 20-bit lane): result bits [2:0] = A[2:0], bits [10:3] = B[7:0], bits [19:11] = 0.
- R2: Selector 1 (two 10-bit lanes, lane k for k = 0, 1): bits [10k+2:10k] = A[4k+2:4k], bits [10k+6:10k+3] = B[4k+3:4k], bits [10k+9:10k+7] = 0.
- R3: Selector 2 (four 5-bit lanes, lane k for k = 0..3): bits [5k+2:5k] = A[4k+2:4k], bits [5k+4:5k+3] = B[2k+1:2k]; no padding.
- R4: The top bit of each A slot (A[3], A[7], A[11], A[15]) has no effect on the result. A slots above the active lane count also have no effect on the result.
- R5: Selector 3 yields a result of all zeros with err_o = 1. Selectors 0 to 2 yield err_o = 0.
- R6: When vld_i is high at a clock edge, res_o, err_o and mode_o (a copy of the selector) take the values computed from that edge's inputs, and vld_o is high for the following cycle.
- R7: When vld_i is low at a clock edge, res_o, err_o and mode_o keep their values and vld_o goes low.
- R8: A low rst_ni at a clock edge clears res_o, err_o, mode_o and vld_o to zero, and takes priority over vld_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Input strobe; the result is captured when it is high |
| elwid_i | input | 2 | Lane-layout selector (0: one lane, 1: two lanes, 2: four lanes, 3: reserved) |
| a_i | input | 16 | Operand A, four 4-bit slots, low three bits used |
| b_i | input | 8 | Operand B, split evenly across the active lanes |
| res_o | output | 20 | Joined result |
| mode_o | output | 2 | Selector value of the captured result |
| err_o | output | 1 | High when the captured selector was the reserved code |
| vld_o | output | 1 | High for one cycle after each capture |

## Verification
Two functions can fall in the same cycle: reset and a capture strobe. The bench provokes this by holding vld_i high, with varied operands, during both the initial reset and a later mid-run reset. It then judges that all outputs read zero rather than a joined result. The second collision is a change of selector between back-to-back strobes, including switches to and from the reserved code. Here each cycle's result must follow only that cycle's selector, its padding must stay zero, and the error flag must be set and cleared on the right edges. A behavioural reference places every field explicitly and is compared on every clock.

// File: rtl/simd_cat_pkg.sv
`timescale 1ns/1ps
package simd_cat_pkg;

    typedef enum logic [1:0] {
        EW_ONE  = 2'd0,
        EW_TWO  = 2'd1,
        EW_FOUR = 2'd2,
        EW_RSVD = 2'd3
    } ew_e;

    // lanes produced by selector code m
    function automatic int lane_count(input int m);
        return 1 << m;
    endfunction

endpackage

// File: rtl/simd_cat_lanes.sv
`timescale 1ns/1ps
// Builds the result word for one fixed lane count.
module simd_cat_lanes #(
    parameter int OUT_W  = 20,
    parameter int A_W    = 16,
    parameter int A_SLOT = 4,
    parameter int A_EW   = 3,
    parameter int B_W    = 8,
    parameter int LANES  = 1
) (
    input  logic [A_W-1:0]   a_i,
    input  logic [B_W-1:0]   b_i,
    output logic [OUT_W-1:0] word_o
);
    localparam int LW  = OUT_W / LANES;
    localparam int BEW = B_W / LANES;
    localparam int PAD = LW - A_EW - BEW;

    // slot top bits and slots above LANES are dropped on purpose
    logic unused_a;
    assign unused_a = ^a_i;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word_o[k*LW +: A_EW]        = a_i[k*A_SLOT +: A_EW];
        assign word_o[k*LW + A_EW +: BEW]  = b_i[k*BEW +: BEW];
        if (PAD > 0) begin : g_pad
            assign word_o[k*LW + A_EW + BEW +: PAD] = '0;
        end
    end
endmodule

// File: rtl/simd_cat_sel.sv
`timescale 1ns/1ps
// Picks the word for the selected layout; reserved codes give zero + error.
module simd_cat_sel #(
    parameter int OUT_W     = 20,
    parameter int EW_W      = 2,
    parameter int NUM_MODES = 3
) (
    input  logic [EW_W-1:0]                  elwid_i,
    input  logic [NUM_MODES-1:0][OUT_W-1:0]  words_i,
    output logic [OUT_W-1:0]                 res_o,
    output logic                             err_o
);
    always_comb begin
        res_o = '0;
        err_o = 1'b1;
        for (int m = 0; m < NUM_MODES; m++) begin
            if (int'(elwid_i) == m) begin
                res_o = words_i[m];
                err_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/simd_cat.sv
`timescale 1ns/1ps
module simd_cat #(
    parameter int OUT_W     = 20,
    parameter int EW_W      = 2,
    parameter int A_W       = 16,
    parameter int A_SLOT    = 4,
    parameter int A_EW      = 3,
    parameter int B_W       = 8,
    parameter int NUM_MODES = 3,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vld_i,
    input  logic [EW_W-1:0]  elwid_i,
    input  logic [A_W-1:0]   a_i,
    input  logic [B_W-1:0]   b_i,
    output logic [OUT_W-1:0] res_o,
    output logic [EW_W-1:0]  mode_o,
    output logic             err_o,
    output logic             vld_o
);
    typedef struct packed {
        logic             vld;
        logic             err;
        logic [EW_W-1:0]  mode;
        logic [OUT_W-1:0] res;
    } out_t;

    logic [NUM_MODES-1:0][OUT_W-1:0] words;
    logic [OUT_W-1:0]                sel_res;
    logic                            sel_err;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        simd_cat_lanes #(
            .OUT_W (OUT_W),
            .A_W   (A_W),
            .A_SLOT(A_SLOT),
            .A_EW  (A_EW),
            .B_W   (B_W),
            .LANES (simd_cat_pkg::lane_count(m))
        ) u_lanes (
            .a_i   (a_i),
            .b_i   (b_i),
            .word_o(words[m])
        );
    end

    simd_cat_sel #(
        .OUT_W    (OUT_W),
        .EW_W     (EW_W),
        .NUM_MODES(NUM_MODES)
    ) u_sel (
        .elwid_i(elwid_i),
        .words_i(words),
        .res_o  (sel_res),
        .err_o  (sel_err)
    );

    if (REG_OUT) begin : g_reg
        out_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = vld_i;
            if (vld_i) begin
                st_d.res  = sel_res;
                st_d.err  = sel_err;
                st_d.mode = elwid_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) st_q <= '0;
            else         st_q <= st_d;
        end

        assign res_o  = st_q.res;
        assign mode_o = st_q.mode;
        assign err_o  = st_q.err;
        assign vld_o  = st_q.vld;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk_i ^ rst_ni;
        assign res_o  = sel_res;
        assign mode_o = elwid_i;
        assign err_o  = sel_err;
        assign vld_o  = vld_i;
    end
endmodule

// File: rtl/simd_cat_chk.sv
`timescale 1ns/1ps
module simd_cat_chk #(
    parameter int OUT_W     = 20,
    parameter int EW_W      = 2,
    parameter int A_EW      = 3,
    parameter int B_W       = 8,
    parameter int NUM_MODES = 3,
    parameter bit REG_OUT   = 1'b1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             vld_i,
    input logic [OUT_W-1:0] res_o,
    input logic [EW_W-1:0]  mode_o,
    input logic             err_o,
    input logic             vld_o
);
    // R5
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_o && err_o) |-> (res_o == '0));

    // R5
    err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> (err_o == (mode_o == EW_W'(simd_cat_pkg::EW_RSVD))));

    // R1 R2 padding stays zero in every lane
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_m
        localparam int LANES = simd_cat_pkg::lane_count(m);
        localparam int LW    = OUT_W / LANES;
        localparam int BEW   = B_W / LANES;
        localparam int PAD   = LW - A_EW - BEW;
        for (genvar k = 0; k < LANES; k++) begin : g_k
            if (PAD > 0) begin : g_p
                zero_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (vld_o && int'(mode_o) == m) |-> (res_o[k*LW + A_EW + BEW +: PAD] == '0));
            end
        end
    end

    if (REG_OUT) begin : g_seq
        // R6
        latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            vld_i |=> vld_o);

        // R7
        hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !vld_i |=> ($stable(res_o) && $stable(mode_o) && $stable(err_o) && !vld_o));

        // R8
        reset_clear_chk: assert property (@(posedge clk_i)
            !rst_ni |=> (res_o == '0 && mode_o == '0 && !err_o && !vld_o));
    end
endmodule

bind simd_cat simd_cat_chk #(
    .OUT_W    (OUT_W),
    .EW_W     (EW_W),
    .A_EW     (A_EW),
    .B_W      (B_W),
    .NUM_MODES(NUM_MODES),
    .REG_OUT  (REG_OUT)
) u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (vld_i),
    .res_o (res_o),
    .mode_o(mode_o),
    .err_o (err_o),
    .vld_o (vld_o)
);

// File: tb/simd_cat_test.sv
`timescale 1ns/1ps
module simd_cat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [1:0]  elwid = 2'd0;
    logic [15:0] a = '0;
    logic [7:0]  b = '0;
    logic [19:0] res_o;
    logic [1:0]  mode_o;
    logic        err_o, vld_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    simd_cat uut (
        .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .elwid_i(elwid),
        .a_i(a), .b_i(b), .res_o(res_o), .mode_o(mode_o),
        .err_o(err_o), .vld_o(vld_o)
    );

    // reference: explicit placement of every field
    function automatic logic [19:0] ref_join(input logic [1:0] e, input logic [15:0] aa,
                                              input logic [7:0] bb);
        logic [19:0] r = '0;
        case (e)
            2'd0: begin r[2:0] = aa[2:0]; r[10:3] = bb; end
            2'd1: begin
                r[2:0]   = aa[2:0]; r[6:3]   = bb[3:0];
                r[12:10] = aa[6:4]; r[16:13] = bb[7:4];
            end
            2'd2: for (int k = 0; k < 4; k++) begin
                r[5*k +: 3]   = aa[4*k +: 3];
                r[5*k+3 +: 2] = bb[2*k +: 2];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] e);
        case (e)
            2'd0: return "R1 R6";
            2'd1: return "R2 R6";
            2'd2: return "R3 R6";
            default: return "R5 R6";
        endcase
    endfunction

    logic [19:0] e_res = '0;
    logic [1:0]  e_mode = '0;
    logic        e_err = 1'b0, e_vld = 1'b0;
    string       e_tag = "R8";
    string       note = "";

    always @(posedge clk) begin
        if (!rst_n) begin
            e_res <= '0; e_mode <= '0; e_err <= 1'b0; e_vld <= 1'b0;
            e_tag <= "R8";
        end else begin
            e_vld <= vld;
            if (vld) begin
                e_res  <= ref_join(elwid, a, b);
                e_mode <= elwid;
                e_err  <= (elwid == 2'd3);
                e_tag  <= {tag_of(elwid), note};
            end else begin
                e_tag <= "R7";
            end
        end
    end

    task automatic compare();
        logic [19:0] mask;
        checks++;
        if (res_o !== e_res || mode_o !== e_mode || err_o !== e_err || vld_o !== e_vld) begin
            fails++;
            $display("FAIL %s: res=%h mode=%0d err=%b vld=%b expected res=%h mode=%0d err=%b vld=%b",
                     e_tag, res_o, mode_o, err_o, vld_o, e_res, e_mode, e_err, e_vld);
        end
        mask = (e_mode == 2'd0) ? 20'hFF800 : (e_mode == 2'd1) ? 20'hE0380 : 20'h0;
        if (e_vld && mask != 0) begin
            checks++;
            if ((res_o & mask) !== 20'h0) begin
                fails++;
                $display("FAIL %s padding: res=%h expected pad bits zero (mask %h)",
                         (e_mode == 2'd0) ? "R1" : "R2", res_o, mask);
            end
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [1:0] e,
                        input logic [15:0] aa, input logic [7:0] bb);
        @(negedge clk);
        compare();
        rst_n = r; vld = v; elwid = e; a = aa; b = bb;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R8: reset with strobe held high
        step(0, 1, 2'd0, 16'hFFFF, 8'hFF);
        step(0, 1, 2'd2, 16'h1234, 8'hA5);
        step(0, 1, 2'd1, 16'hBEEF, 8'h3C);
        // R1 R2 R3 directed
        step(1, 1, 2'd0, 16'h0007, 8'hFF);
        step(1, 1, 2'd0, 16'hFFF5, 8'h81);
        step(1, 1, 2'd1, 16'h0077, 8'hFF);
        step(1, 1, 2'd1, 16'hFFFF, 8'h5A);
        step(1, 1, 2'd2, 16'h7777, 8'hFF);
        step(1, 1, 2'd2, 16'h1357, 8'hE4);
        // R4: slot top bits and unused slots flipped
        note = " R4";
        step(1, 1, 2'd2, 16'h8888, 8'h00);
        step(1, 1, 2'd0, 16'hFFF8, 8'h00);
        step(1, 1, 2'd1, 16'hFF88, 8'h00);
        step(1, 1, 2'd1, 16'h0000, 8'h00);
        note = "";
        // R5: reserved, then back to a valid code
        step(1, 1, 2'd3, 16'hFFFF, 8'hFF);
        step(1, 1, 2'd2, 16'hFFFF, 8'hFF);
        step(1, 1, 2'd3, 16'h1234, 8'h56);
        // R7: idle keeps last result
        step(1, 0, 2'd0, 16'hFFFF, 8'hFF);
        step(1, 0, 2'd1, 16'h0F0F, 8'h33);
        step(1, 1, 2'd1, 16'h4321, 8'h9C);
        step(1, 0, 2'd2, 16'hAAAA, 8'h55);
        step(1, 0, 2'd3, 16'h5555, 8'hAA);
        // random traffic with a mid-run reset under strobe
        for (int i = 0; i < 600; i++) begin
            step((i % 200 == 150) ? 1'b0 : 1'b1, ($urandom % 4) != 0,
                 2'($urandom), 16'($urandom), 8'($urandom));
        end
        step(1, 0, 2'd0, 16'h0, 8'h0);
        step(1, 0, 2'd0, 16'h0, 8'h0);
        finish_run();
    end
endmodule